// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block sits on the write side of a NOR parallel flash model and turns the stream of bus write strobes into flash operations. Each write carries a byte address and a data byte. The sequencer checks these writes against the multi-cycle unlock protocol of the common parallel-flash command set. It keeps a write-step counter, the command that is open, an unlock-bypass flag and a flag that records where a query session should return. When a sequence completes, it issues a one-cycle request to program a location, erase one sector or erase the whole chip.

The memory array, the erase timers and the read data path live elsewhere. The read path learns from `readSel` whether a read should return array data, identifier data, query-table data or status. The erase timer reports through two inputs. `eraseWindowOpen` says that further sector-erase commands may still be queued. `eraseDone` ends an erase in progress.

The byte address is turned into a word index by shifting it right according to the bus width and keeping the low 11 bits. The two unlock addresses and the query-entry index are compared against this word index. All three are parameters.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, `seqStep` is 0, `readSel` is 0 (array), `bypassOn` is 0, and none of the three request outputs is high.
- R2: The four-write program sequence triggers `progReq` for exactly one cycle, in the cycle after the data write. The four writes are 0xAA at unlock address A0 (default word 0x555), 0x55 at unlock address A1 (default 0x2AA), 0xA0 at A0, and then the data write. `reqAddr` and `reqData` hold that write's byte address and data. The sequencer then returns to step 0. Between the 0xA0 write and the data write, `readSel` is 3 (status) and `seqStep` is 3.
- R3: A write at step 0 or step 1 whose data or word index does not match the expected unlock write returns the sequencer to step 0 with no request. At step 0, a 0x98 write at word index 0x55 is the exception (see R5).
- R4: The unlock pair followed by 0x90 at A0 selects identifier reads (`readSel` = 1). A following 0xF0 at any address returns to array reads at step 0.
- R5: At step 0, a 0x98 write at word index 0x55 selects query reads (`readSel` = 2). While in query mode, any write returns the sequencer to array reads at step 0; this includes 0xF0.
- R6: In identifier mode, a 0x98 write at word index 0x55 selects query reads. A following 0xF0 returns the sequencer to identifier reads at step 3 instead of to array reads.
- R7: Chip erase follows an erase-setup sequence: an unlock pair, 0x80 at A0, and a second unlock pair. A 0x10 write at A0 then triggers `chipEraseReq` for one cycle and selects status reads. If the 0x10 is written at any other word index, the sequencer resets instead. While the chip erase runs, all writes are ignored, 0xF0 included. `eraseDone` ends the erase. The sequencer returns to step 0, or to step 2 with bypass still on if bypass was active.
- R8: After an erase-setup sequence, 0x30 at any address triggers `sectEraseReq` with that address. While `eraseWindowOpen` is high, each further 0x30 write triggers another request, and any other data resets the sequencer. While `eraseWindowOpen` is low, writes are ignored, 0xF0 included. `eraseDone` returns the sequencer to array reads.
- R9: The unlock pair followed by 0x20 at A0 sets `bypassOn` and leaves the sequencer at step 2. In bypass, 0xA0 at any address followed by a data write triggers `progReq` and returns to step 2 with bypass still on.
- R10: In bypass, 0x90 selects identifier reads, and a following 0x00 write clears `bypassOn` and returns to step 0. A 0xF0 at bypass step 2 also clears `bypassOn`.
- R11: The word index is the byte address shifted right by `busWidth` (0: 8-bit, 1: 16-bit, 2: 32-bit) with only its low 11 bits kept. Byte-address bits above the index do not affect unlock matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Bus write strobe, one cycle per write |
| wrAddr | input | ADDR_W | Byte address of the write |
| wrData | input | 8 | Command or data byte of the write |
| busWidth | input | 2 | Bus width code: 0 = 8-bit, 1 = 16-bit, 2 or 3 = 32-bit |
| eraseWindowOpen | input | 1 | High while further sector-erase commands are accepted |
| eraseDone | input | 1 | One-cycle pulse that ends an erase in progress |
| readSel | output | 2 | Read source: 0 array, 1 identifier, 2 query, 3 status |
| bypassOn | output | 1 | Unlock bypass is active |
| seqStep | output | 3 | Current write step (7 while in query mode) |
| progReq | output | 1 | One-cycle program request |
| sectEraseReq | output | 1 | One-cycle sector erase request |
| chipEraseReq | output | 1 | One-cycle chip erase request |
| reqAddr | output | ADDR_W | Byte address of the last request |
| reqData | output | 8 | Data byte of the last request |

## Verification
A wrong step counter or a wrong open command shows at the ports in the cycle after the write that caused it. `seqStep` and `readSel` move to values that differ from those the protocol gives. At the latest, the next write in the sequence produces a missing or extra request pulse. A bypass flag that fails to clear shows at once on `bypassOn`. It also shows one write later, when a program is accepted without an unlock pair. A lost query return point shows on `readSel` directly after the 0xF0 write that leaves query mode.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_ERSETUP,
    CMD_AUTOSEL,
    CMD_PROG,
    CMD_CHIPER,
    CMD_SECTER,
    CMD_CFI
  } cmd_e;

  localparam logic [1:0] RS_ARRAY  = 2'd0;
  localparam logic [1:0] RS_ID     = 2'd1;
  localparam logic [1:0] RS_CFI    = 2'd2;
  localparam logic [1:0] RS_STATUS = 2'd3;

  localparam logic [7:0] DB_UNLOCK1 = 8'hAA;
  localparam logic [7:0] DB_UNLOCK2 = 8'h55;
  localparam logic [7:0] DB_BYPASS  = 8'h20;
  localparam logic [7:0] DB_ERASE   = 8'h80;
  localparam logic [7:0] DB_AUTOSEL = 8'h90;
  localparam logic [7:0] DB_PROG    = 8'hA0;
  localparam logic [7:0] DB_CHIP    = 8'h10;
  localparam logic [7:0] DB_SECT    = 8'h30;
  localparam logic [7:0] DB_QUERY   = 8'h98;
  localparam logic [7:0] DB_RESET   = 8'hF0;
  localparam logic [7:0] DB_BYPEXIT = 8'h00;

  localparam logic [2:0] STEP_QUERY = 3'd7;

  typedef struct packed {
    logic hitA0;
    logic hitA1;
    logic hitCfi;
  } addrHit_t;

  typedef struct packed {
    logic prog;
    logic sect;
    logic chip;
  } reqStb_t;

endpackage

// File: rtl/fcs_datapath.sv
module fcs_datapath
  import fcs_pkg::*;
#(
  parameter int          ADDR_W    = 24,
  parameter int          IDX_W     = 11,
  parameter logic [10:0] UNLOCK_A0 = 11'h555,
  parameter logic [10:0] UNLOCK_A1 = 11'h2AA,
  parameter logic [10:0] CFI_IDX   = 11'h055
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic [1:0]        busWidth,
  input  reqStb_t           stb,
  output addrHit_t          hit,
  output logic              progReq,
  output logic              sectEraseReq,
  output logic              chipEraseReq,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [7:0]        reqData
);

  localparam int MAX_SHIFT = 2;
  localparam int MIN_ADDR_W = IDX_W + MAX_SHIFT;

  logic [IDX_W-1:0] wordIdx;
  logic             anyStb;

  initial begin
    if (ADDR_W < MIN_ADDR_W) $error("ADDR_W too small for the word index");
  end

  always_comb begin
    case (busWidth)
      2'd0:    wordIdx = wrAddr[IDX_W-1:0];
      2'd1:    wordIdx = wrAddr[IDX_W:1];
      default: wordIdx = wrAddr[IDX_W+1:2];
    endcase
  end

  always_comb begin
    hit.hitA0  = (wordIdx == UNLOCK_A0[IDX_W-1:0]);
    hit.hitA1  = (wordIdx == UNLOCK_A1[IDX_W-1:0]);
    hit.hitCfi = (wordIdx == CFI_IDX[IDX_W-1:0]);
  end

  assign anyStb = stb.prog | stb.sect | stb.chip;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      progReq      <= 1'b0;
      sectEraseReq <= 1'b0;
      chipEraseReq <= 1'b0;
      reqAddr      <= '0;
      reqData      <= '0;
    end else begin
      progReq      <= stb.prog;
      sectEraseReq <= stb.sect;
      chipEraseReq <= stb.chip;
      if (anyStb) begin
        reqAddr <= wrAddr;
        reqData <= wrData;
      end
    end
  end

endmodule

// File: rtl/fcs_ctrl.sv
module fcs_ctrl
  import fcs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  addrHit_t   hit,
  input  logic       eraseWindowOpen,
  input  logic       eraseDone,
  output reqStb_t    stb,
  output logic [1:0] readSel,
  output logic       bypassOn,
  output logic [2:0] seqStep
);

  cmd_e       cmdQ, cmdD;
  logic [2:0] stepQ, stepD;
  logic       bypQ, bypD;
  logic       retQ, retD;
  logic       goIdle;
  logic       busy;
  logic       unlock1Ok;
  logic       queryHit;

  assign busy      = (cmdQ == CMD_CHIPER) || (cmdQ == CMD_SECTER);
  assign unlock1Ok = hit.hitA0 && (wrData == DB_UNLOCK1);
  assign queryHit  = hit.hitCfi && (wrData == DB_QUERY);

  always_comb begin
    cmdD   = cmdQ;
    stepD  = stepQ;
    bypD   = bypQ;
    retD   = retQ;
    stb    = '0;
    goIdle = 1'b0;

    if (busy && eraseDone) begin
      cmdD  = CMD_NONE;
      stepD = bypQ ? 3'd2 : 3'd0;
    end else if (wrEn) begin
      if (wrData == DB_RESET && cmdQ != CMD_PROG && !busy) begin
        if (cmdQ == CMD_CFI && retQ) begin
          cmdD  = CMD_AUTOSEL;
          stepD = 3'd3;
          retD  = 1'b0;
        end else begin
          goIdle = 1'b1;
        end
      end else if (cmdQ == CMD_CFI) begin
        goIdle = 1'b1;
      end else begin
        case (stepQ)
          3'd0: begin
            if (queryHit) begin
              cmdD  = CMD_CFI;
              retD  = 1'b0;
              stepD = STEP_QUERY;
            end else if (unlock1Ok) begin
              stepD = 3'd1;
            end else begin
              goIdle = 1'b1;
            end
          end
          3'd1: begin
            if (hit.hitA1 && wrData == DB_UNLOCK2) stepD = 3'd2;
            else goIdle = 1'b1;
          end
          3'd2: begin
            if (!bypQ && !hit.hitA0) begin
              goIdle = 1'b1;
            end else begin
              case (wrData)
                DB_BYPASS: begin
                  bypD  = 1'b1;
                  cmdD  = CMD_NONE;
                  stepD = 3'd2;
                end
                DB_ERASE: begin
                  cmdD  = CMD_ERSETUP;
                  stepD = 3'd3;
                end
                DB_AUTOSEL: begin
                  cmdD  = CMD_AUTOSEL;
                  stepD = 3'd3;
                end
                DB_PROG: begin
                  cmdD  = CMD_PROG;
                  stepD = 3'd3;
                end
                default: goIdle = 1'b1;
              endcase
            end
          end
          3'd3: begin
            case (cmdQ)
              CMD_ERSETUP: begin
                if (queryHit) begin
                  cmdD  = CMD_CFI;
                  retD  = 1'b0;
                  stepD = STEP_QUERY;
                end else if (unlock1Ok) begin
                  stepD = 3'd4;
                end else begin
                  goIdle = 1'b1;
                end
              end
              CMD_PROG: begin
                stb.prog = 1'b1;
                if (bypQ) begin
                  cmdD  = CMD_NONE;
                  stepD = 3'd2;
                end else begin
                  goIdle = 1'b1;
                end
              end
              CMD_AUTOSEL: begin
                if (bypQ && wrData == DB_BYPEXIT) begin
                  goIdle = 1'b1;
                end else if (queryHit) begin
                  cmdD  = CMD_CFI;
                  retD  = 1'b1;
                  stepD = STEP_QUERY;
                end else begin
                  goIdle = 1'b1;
                end
              end
              default: goIdle = 1'b1;
            endcase
          end
          3'd4: begin
            if (cmdQ == CMD_ERSETUP && hit.hitA1 && wrData == DB_UNLOCK2)
              stepD = 3'd5;
            else
              goIdle = 1'b1;
          end
          3'd5: begin
            if (wrData == DB_CHIP && hit.hitA0) begin
              stb.chip = 1'b1;
              cmdD     = CMD_CHIPER;
              stepD    = 3'd6;
            end else if (wrData == DB_SECT) begin
              stb.sect = 1'b1;
              cmdD     = CMD_SECTER;
              stepD    = 3'd6;
            end else begin
              goIdle = 1'b1;
            end
          end
          3'd6: begin
            case (cmdQ)
              CMD_CHIPER: ;
              CMD_SECTER: begin
                if (eraseWindowOpen) begin
                  if (wrData == DB_SECT) stb.sect = 1'b1;
                  else goIdle = 1'b1;
                end
              end
              default: goIdle = 1'b1;
            endcase
          end
          default: goIdle = 1'b1;
        endcase
      end

      if (goIdle) begin
        cmdD  = CMD_NONE;
        stepD = 3'd0;
        bypD  = 1'b0;
        retD  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ  <= CMD_NONE;
      stepQ <= 3'd0;
      bypQ  <= 1'b0;
      retQ  <= 1'b0;
    end else begin
      cmdQ  <= cmdD;
      stepQ <= stepD;
      bypQ  <= bypD;
      retQ  <= retD;
    end
  end

  always_comb begin
    case (cmdQ)
      CMD_CFI:                         readSel = RS_CFI;
      CMD_AUTOSEL:                     readSel = RS_ID;
      CMD_PROG, CMD_CHIPER, CMD_SECTER: readSel = RS_STATUS;
      default:                         readSel = RS_ARRAY;
    endcase
  end

  assign bypassOn = bypQ;
  assign seqStep  = stepQ;

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fcs_pkg::*;
#(
  parameter int          ADDR_W    = 24,
  parameter int          IDX_W     = 11,
  parameter logic [10:0] UNLOCK_A0 = 11'h555,
  parameter logic [10:0] UNLOCK_A1 = 11'h2AA,
  parameter logic [10:0] CFI_IDX   = 11'h055
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic [1:0]        busWidth,
  input  logic              eraseWindowOpen,
  input  logic              eraseDone,
  output logic [1:0]        readSel,
  output logic              bypassOn,
  output logic [2:0]        seqStep,
  output logic              progReq,
  output logic              sectEraseReq,
  output logic              chipEraseReq,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [7:0]        reqData
);

  addrHit_t hit;
  reqStb_t  stb;

  fcs_datapath #(
    .ADDR_W   (ADDR_W),
    .IDX_W    (IDX_W),
    .UNLOCK_A0(UNLOCK_A0),
    .UNLOCK_A1(UNLOCK_A1),
    .CFI_IDX  (CFI_IDX)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .wrAddr      (wrAddr),
    .wrData      (wrData),
    .busWidth    (busWidth),
    .stb         (stb),
    .hit         (hit),
    .progReq     (progReq),
    .sectEraseReq(sectEraseReq),
    .chipEraseReq(chipEraseReq),
    .reqAddr     (reqAddr),
    .reqData     (reqData)
  );

  fcs_ctrl u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .wrEn           (wrEn),
    .wrData         (wrData),
    .hit            (hit),
    .eraseWindowOpen(eraseWindowOpen),
    .eraseDone      (eraseDone),
    .stb            (stb),
    .readSel        (readSel),
    .bypassOn       (bypassOn),
    .seqStep        (seqStep)
  );

endmodule

// File: rtl/fcs_chk.sv
module fcs_chk
  import fcs_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [7:0] wrData,
  input logic       eraseDone,
  input logic [1:0] readSel,
  input logic       bypassOn,
  input logic       progReq,
  input logic       sectEraseReq,
  input logic       chipEraseReq
);

  // R2, R7, R8: at most one request per cycle
  p_one_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({progReq, sectEraseReq, chipEraseReq}));

  // R2: a program request always follows a write
  p_prog_after_wr_r2: assert property (@(posedge clk) disable iff (!rstN)
    progReq |-> $past(wrEn));

  // R7: chip erase request comes with status reads
  p_chip_status_r7: assert property (@(posedge clk) disable iff (!rstN)
    chipEraseReq |-> (readSel == RS_STATUS));

  // R7: status reads persist with no write and no completion
  p_status_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (readSel == RS_STATUS && !wrEn && !eraseDone) |=> (readSel == RS_STATUS));

  // R4: 0xF0 in identifier mode returns to array reads without bypass
  p_id_exit_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData == DB_RESET && readSel == RS_ID) |=> (readSel == RS_ARRAY && !bypassOn));

  // R9: bypass only rises after a 0x20 write
  p_bypass_entry_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bypassOn) |-> ($past(wrEn) && $past(wrData) == DB_BYPASS));

endmodule

bind flash_cmd_seq fcs_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .wrEn        (wrEn),
  .wrData      (wrData),
  .eraseDone   (eraseDone),
  .readSel     (readSel),
  .bypassOn    (bypassOn),
  .progReq     (progReq),
  .sectEraseReq(sectEraseReq),
  .chipEraseReq(chipEraseReq)
);

// File: tb/sim_flash_cmd_seq.sv
module sim_flash_cmd_seq;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 24;
  localparam logic [10:0] A0 = 11'h555;
  localparam logic [10:0] A1 = 11'h2AA;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [7:0]        wrData = '0;
  logic [1:0]        busWidth = 2'd0;
  logic              eraseWindowOpen = 1'b0;
  logic              eraseDone = 1'b0;
  logic [1:0]        readSel;
  logic              bypassOn;
  logic [2:0]        seqStep;
  logic              progReq, sectEraseReq, chipEraseReq;
  logic [ADDR_W-1:0] reqAddr;
  logic [7:0]        reqData;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_seq u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .busWidth(busWidth), .eraseWindowOpen(eraseWindowOpen), .eraseDone(eraseDone),
    .readSel(readSel), .bypassOn(bypassOn), .seqStep(seqStep),
    .progReq(progReq), .sectEraseReq(sectEraseReq), .chipEraseReq(chipEraseReq),
    .reqAddr(reqAddr), .reqData(reqData)
  );

  function automatic logic [ADDR_W-1:0] byteAddr(input logic [10:0] idx,
                                                 input logic [1:0] bw,
                                                 input logic [10:0] junk);
    int sh;
    logic [47:0] full;
    sh = (bw == 2'd0) ? 0 : (bw == 2'd1) ? 1 : 2;
    full = (48'(junk) << (11 + sh)) | (48'(idx) << sh);
    return full[ADDR_W-1:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrByte(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic wrIdx(input logic [10:0] idx, input logic [7:0] d);
    wrByte(byteAddr(idx, busWidth, 11'd0), d);
  endtask

  task automatic unlockPair();
    wrIdx(A0, 8'hAA);
    wrIdx(A1, 8'h55);
  endtask

  task automatic pulseDone();
    @(negedge clk);
    eraseDone = 1'b1;
    @(negedge clk);
    eraseDone = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 step", 32'(seqStep), 0);
    check("R1 readSel", 32'(readSel), 0);
    check("R1 bypass", 32'(bypassOn), 0);
    check("R1 reqs", 32'({progReq, sectEraseReq, chipEraseReq}), 0);

    // R2 program
    unlockPair();
    wrIdx(A0, 8'hA0);
    check("R2 status during program", 32'(readSel), 3);
    check("R2 step3", 32'(seqStep), 3);
    wrByte(24'h001234, 8'h5A);
    check("R2 progReq", 32'(progReq), 1);
    check("R2 reqAddr", 32'(reqAddr), 32'h1234);
    check("R2 reqData", 32'(reqData), 32'h5A);
    check("R2 back to step0", 32'(seqStep), 0);
    check("R2 array", 32'(readSel), 0);
    idle();
    check("R2 single pulse", 32'(progReq), 0);

    // R3 bad unlock
    wrIdx(A0, 8'hAA);
    check("R3 step1", 32'(seqStep), 1);
    wrIdx(11'h100, 8'h55);
    check("R3 bad addr resets", 32'(seqStep), 0);
    wrIdx(A0, 8'h11);
    check("R3 bad data resets", 32'(seqStep), 0);
    for (int i = 0; i < 20; i++) begin
      logic [7:0] d;
      logic [10:0] ix;
      d = 8'($urandom);
      if (d == 8'hAA || d == 8'h98) d = 8'h01;
      ix = 11'($urandom);
      wrIdx(ix, d);
      check("R3 random junk step", 32'(seqStep), 0);
      check("R3 random junk req", 32'({progReq, sectEraseReq, chipEraseReq}), 0);
    end

    // R4 autoselect
    unlockPair();
    wrIdx(A0, 8'h90);
    check("R4 id mode", 32'(readSel), 1);
    wrIdx(11'h033, 8'hF0);
    check("R4 exit to array", 32'(readSel), 0);
    check("R4 exit step", 32'(seqStep), 0);

    // R5 direct query
    wrIdx(11'h055, 8'h98);
    check("R5 query mode", 32'(readSel), 2);
    wrIdx(11'h010, 8'h33);
    check("R5 other write exits", 32'(readSel), 0);
    wrIdx(11'h055, 8'h98);
    wrIdx(11'h000, 8'hF0);
    check("R5 F0 exits", 32'(readSel), 0);
    check("R5 F0 step", 32'(seqStep), 0);

    // R6 query from autoselect
    unlockPair();
    wrIdx(A0, 8'h90);
    wrIdx(11'h055, 8'h98);
    check("R6 query", 32'(readSel), 2);
    wrIdx(11'h000, 8'hF0);
    check("R6 back to id", 32'(readSel), 1);
    check("R6 step3", 32'(seqStep), 3);
    wrIdx(11'h055, 8'h12);
    check("R6 then reset", 32'(readSel), 0);

    // R7 chip erase
    unlockPair(); wrIdx(A0, 8'h80); unlockPair();
    check("R7 step5", 32'(seqStep), 5);
    wrIdx(11'h123, 8'h10);
    check("R7 wrong addr resets", 32'(seqStep), 0);
    check("R7 wrong addr no req", 32'(chipEraseReq), 0);
    unlockPair(); wrIdx(A0, 8'h80); unlockPair();
    wrIdx(A0, 8'h10);
    check("R7 chipEraseReq", 32'(chipEraseReq), 1);
    check("R7 status", 32'(readSel), 3);
    wrIdx(11'h000, 8'hF0);
    check("R7 F0 ignored", 32'(readSel), 3);
    check("R7 F0 ignored step", 32'(seqStep), 6);
    pulseDone();
    check("R7 done array", 32'(readSel), 0);
    check("R7 done step", 32'(seqStep), 0);
    // R7 erase completion under bypass
    unlockPair(); wrIdx(A0, 8'h20);
    wrIdx(11'h001, 8'h80); unlockPair();
    wrIdx(A0, 8'h10);
    check("R7 bypass chip req", 32'(chipEraseReq), 1);
    pulseDone();
    check("R7 bypass done step2", 32'(seqStep), 2);
    check("R7 bypass kept", 32'(bypassOn), 1);
    wrIdx(11'h000, 8'hF0);

    // R8 sector erase
    eraseWindowOpen = 1'b1;
    unlockPair(); wrIdx(A0, 8'h80); unlockPair();
    wrByte(24'h000400, 8'h30);
    check("R8 sect req", 32'(sectEraseReq), 1);
    check("R8 sect addr", 32'(reqAddr), 32'h400);
    wrByte(24'h000800, 8'h30);
    check("R8 extra sect req", 32'(sectEraseReq), 1);
    check("R8 extra sect addr", 32'(reqAddr), 32'h800);
    wrByte(24'h000000, 8'h55);
    check("R8 other data resets", 32'(readSel), 0);
    unlockPair(); wrIdx(A0, 8'h80); unlockPair();
    wrByte(24'h001000, 8'h30);
    eraseWindowOpen = 1'b0;
    wrByte(24'h000000, 8'hF0);
    check("R8 closed F0 ignored", 32'(readSel), 3);
    wrByte(24'h002000, 8'h30);
    check("R8 closed 30 ignored", 32'(sectEraseReq), 0);
    pulseDone();
    check("R8 done array", 32'(readSel), 0);

    // R9 bypass program
    unlockPair(); wrIdx(A0, 8'h20);
    check("R9 bypass on", 32'(bypassOn), 1);
    check("R9 step2", 32'(seqStep), 2);
    wrByte(24'h000077, 8'hA0);
    check("R9 step3", 32'(seqStep), 3);
    wrByte(24'h000099, 8'h3C);
    check("R9 prog", 32'(progReq), 1);
    check("R9 data", 32'(reqData), 32'h3C);
    check("R9 back step2", 32'(seqStep), 2);
    check("R9 still bypass", 32'(bypassOn), 1);

    // R10 bypass exit
    wrByte(24'h000010, 8'h90);
    check("R10 id in bypass", 32'(readSel), 1);
    wrByte(24'h000000, 8'h00);
    check("R10 exit bypass", 32'(bypassOn), 0);
    check("R10 exit step", 32'(seqStep), 0);
    unlockPair(); wrIdx(A0, 8'h20);
    wrByte(24'h000000, 8'hF0);
    check("R10 F0 clears bypass", 32'(bypassOn), 0);

    // R11 word index per width
    for (int bw = 0; bw < 3; bw++) begin
      busWidth = 2'(bw);
      wrByte(byteAddr(A0, busWidth, 11'($urandom)), 8'hAA);
      check("R11 first unlock", 32'(seqStep), 1);
      wrByte(byteAddr(A1, busWidth, 11'($urandom)), 8'h55);
      check("R11 second unlock", 32'(seqStep), 2);
      wrByte(byteAddr(A0, busWidth, 11'($urandom)), 8'h90);
      check("R11 id", 32'(readSel), 1);
      wrByte(24'h0, 8'hF0);
    end
    busWidth = 2'd1;
    wrByte(24'h000555, 8'hAA);
    check("R11 unshifted addr rejected", 32'(seqStep), 0);
    busWidth = 2'd0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule